// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block keeps the configuration of a small set of hardware breakpoint triggers and presents it to software as a few control and status registers. Software picks one trigger through an index register and then reads or writes that trigger's control word and compare value. Triggers that the debugger has claimed for itself (their debug-only bit is set) cannot be changed by ordinary software; such writes are silently dropped unless the core is in debug mode.

From the stored control words the block derives three enables that tell the memory pipeline whether instruction fetch, load or store addresses need to be compared against any trigger. These enables follow every accepted control-word write, and each such write also raises a one-cycle pulse asking the address translation logic to flush, since cached translations may have skipped trigger checks. The comparison itself and what happens on a match live elsewhere.

Reads are combinational from the address; writes land on the rising clock edge; reset is synchronous and active high. The register addresses are 0x7A0 (index), 0x7A1 (control word), 0x7A2 (compare value) and 0x7A3 (third data word, always zero).

Top module: `dbg_trig_bank`

## Requirements
- R1: After reset the index reads 0, every trigger's control word reads 0x2000_0000 (type field bits 31:28 equal to 2, all other bits 0), every compare value reads 0, the three check enables are 0 and the flush pulse is 0.
- R2: A write to the index register (0x7A0) is taken only when the full 32-bit write value is below the trigger count (default 4); otherwise the previous index is kept. The index reads back zero-extended.
- R3: A control-word write (0x7A1) to the selected trigger stores bit 27 (debug-only) and bits 19:0; the word then reads back as the written value masked with 0x080F_FFFF, with 2 in bits 31:28 and zero in bits 26:20.
- R4: If a control-word write has bit 2 (execute) set, the stored bit 18 (timing) becomes 0 whatever value was written; with bit 2 clear, bit 18 is stored as written.
- R5: While the selected trigger's stored bit 27 is 1 and the debug-mode input is 0, writes to its control word and compare value leave it unchanged; with the debug-mode input at 1 they are taken.
- R6: A compare-value write (0x7A2) stores all 32 bits for the selected trigger only, and reading 0x7A2 returns the selected trigger's compare value.
- R7: Address 0x7A3 and any address outside 0x7A0..0x7A3 read as 0.
- R8: The fetch, load and store check enables equal the OR over all triggers of control bits 2, 0 and 1 respectively.
- R9: The flush output is 1 for exactly the one cycle after a taken control-word write and 0 otherwise (no pulse for dropped writes or other registers).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_we_i | input | 1 | Write enable |
| csr_rdata_o | output | 32 | Read data, combinational from the address |
| dbg_mode_i | input | 1 | Core is in debug mode |
| chk_fetch_o | output | 1 | Some trigger watches instruction fetch |
| chk_load_o | output | 1 | Some trigger watches loads |
| chk_store_o | output | 1 | Some trigger watches stores |
| xlat_flush_o | output | 1 | One-cycle translation flush request |

## Verification
The hardest state to reach is a trigger that carries the debug-only bit while ordinary software keeps writing to it, because the bit can only be set by a write that is itself accepted and the lock then hides every later attempt. The stimulus sets the bit through an unlocked write, then issues control and compare writes with the debug-mode input both low and high, and the random phase biases bit 27 and toggles debug mode often so locked and unlocked triggers coexist while the index moves, including out-of-range index values.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int XLEN = 32;

    localparam logic [11:0] ADDR_INDEX = 12'h7A0;
    localparam logic [11:0] ADDR_CTRL  = 12'h7A1;
    localparam logic [11:0] ADDR_CMP   = 12'h7A2;
    localparam logic [11:0] ADDR_AUX   = 12'h7A3;

    localparam logic [3:0] TRIG_KIND   = 4'd2;

    typedef struct packed {
        logic       dbg_only;
        logic       sel_data;
        logic       timing;
        logic [5:0] action;
        logic       chain;
        logic [3:0] match;
        logic       pm;
        logic       ph;
        logic       ps;
        logic       pu;
        logic       exec;
        logic       st;
        logic       ld;
    } trig_ctrl_t;

    function automatic logic [XLEN-1:0] pack_ctrl(input trig_ctrl_t c);
        return {TRIG_KIND, c.dbg_only, 7'd0, c.sel_data, c.timing, c.action,
                c.chain, c.match, c.pm, c.ph, c.ps, c.pu, c.exec, c.st, c.ld};
    endfunction

    function automatic trig_ctrl_t unpack_ctrl(input logic [XLEN-1:0] w);
        trig_ctrl_t c;
        c.dbg_only = w[27];
        c.sel_data = w[19];
        c.timing   = w[18] & ~w[2];
        c.action   = w[17:12];
        c.chain    = w[11];
        c.match    = w[10:7];
        c.pm       = w[6];
        c.ph       = w[5];
        c.ps       = w[4];
        c.pu       = w[3];
        c.exec     = w[2];
        c.st       = w[1];
        c.ld       = w[0];
        return c;
    endfunction

endpackage

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
    import dbg_trig_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ctrl_we_i,
    input  logic            cmp_we_i,
    input  logic [XLEN-1:0] wdata_i,
    output trig_ctrl_t      ctrl_o,
    output logic [XLEN-1:0] cmp_o
);

    typedef struct packed {
        trig_ctrl_t      ctrl;
        logic [XLEN-1:0] cmp;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we_i) st_d.ctrl = unpack_ctrl(wdata_i);
        if (cmp_we_i)  st_d.cmp  = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign cmp_o  = st_q.cmp;

endmodule

// File: rtl/dbg_trig_summary.sv
module dbg_trig_summary
    import dbg_trig_pkg::*;
#(
    parameter int N_TRIG = 4
)(
    input  trig_ctrl_t ctrl_i [N_TRIG],
    output logic       fetch_o,
    output logic       load_o,
    output logic       store_o
);

    always_comb begin
        fetch_o = 1'b0;
        load_o  = 1'b0;
        store_o = 1'b0;
        for (int k = 0; k < N_TRIG; k++) begin
            fetch_o = fetch_o | ctrl_i[k].exec;
            load_o  = load_o  | ctrl_i[k].ld;
            store_o = store_o | ctrl_i[k].st;
        end
    end

endmodule

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank
    import dbg_trig_pkg::*;
#(
    parameter int N_TRIG = 4
)(
    input  logic            clk,
    input  logic            rst,
    input  logic [11:0]     csr_addr_i,
    input  logic [31:0]     csr_wdata_i,
    input  logic            csr_we_i,
    output logic [31:0]     csr_rdata_o,
    input  logic            dbg_mode_i,
    output logic            chk_fetch_o,
    output logic            chk_load_o,
    output logic            chk_store_o,
    output logic            xlat_flush_o
);

    localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             flush;
    } bank_state_t;

    bank_state_t st_d, st_q;

    trig_ctrl_t      ctrl_arr [N_TRIG];
    logic [XLEN-1:0] cmp_arr  [N_TRIG];

    logic             ctrl_take;
    logic             cmp_take;
    logic             locked;
    trig_ctrl_t       cur_ctrl;
    logic [XLEN-1:0]  cur_word;
    logic [SEL_W-1:0] sel_cur;

    assign sel_cur  = st_q.sel;
    assign cur_ctrl = ctrl_arr[st_q.sel];
    assign cur_word = pack_ctrl(cur_ctrl);

    always_comb begin
        locked    = cur_ctrl.dbg_only & ~dbg_mode_i;
        ctrl_take = csr_we_i && (csr_addr_i == ADDR_CTRL) && !locked;
        cmp_take  = csr_we_i && (csr_addr_i == ADDR_CMP)  && !locked;

        st_d       = st_q;
        st_d.flush = ctrl_take;
        if (csr_we_i && (csr_addr_i == ADDR_INDEX) && (csr_wdata_i < 32'(N_TRIG)))
            st_d.sel = csr_wdata_i[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar k = 0; k < N_TRIG; k++) begin : g_slot
        logic slot_hit;
        assign slot_hit = (st_q.sel == SEL_W'(k));
        dbg_trig_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .ctrl_we_i (ctrl_take && slot_hit),
            .cmp_we_i  (cmp_take && slot_hit),
            .wdata_i   (csr_wdata_i),
            .ctrl_o    (ctrl_arr[k]),
            .cmp_o     (cmp_arr[k])
        );
    end

    dbg_trig_summary #(.N_TRIG(N_TRIG)) u_summary (
        .ctrl_i  (ctrl_arr),
        .fetch_o (chk_fetch_o),
        .load_o  (chk_load_o),
        .store_o (chk_store_o)
    );

    always_comb begin
        case (csr_addr_i)
            ADDR_INDEX: csr_rdata_o = 32'(st_q.sel);
            ADDR_CTRL:  csr_rdata_o = cur_word;
            ADDR_CMP:   csr_rdata_o = cmp_arr[st_q.sel];
            default:    csr_rdata_o = '0;
        endcase
    end

    assign xlat_flush_o = st_q.flush;

endmodule

// File: rtl/dbg_trig_bank_chk.sv
module dbg_trig_bank_chk #(
    parameter int N_TRIG = 4,
    parameter int SEL_W  = 2
)(
    input logic             clk,
    input logic             rst,
    input logic [11:0]      csr_addr_i,
    input logic [31:0]      csr_wdata_i,
    input logic             csr_we_i,
    input logic [31:0]      csr_rdata_o,
    input logic             dbg_mode_i,
    input logic             chk_fetch_o,
    input logic             chk_load_o,
    input logic             chk_store_o,
    input logic             xlat_flush_o,
    input logic [SEL_W-1:0] sel_cur,
    input logic [31:0]      cur_word
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (sel_cur == '0) && !xlat_flush_o && !chk_fetch_o && !chk_load_o && !chk_store_o);

    // R2
    index_range_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we_i && csr_addr_i == 12'h7A0 && csr_wdata_i >= 32'(N_TRIG)) |=> $stable(sel_cur));

    // R4
    timing_forced_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we_i && csr_addr_i == 12'h7A1 && csr_wdata_i[2] && !(cur_word[27] && !dbg_mode_i))
        |=> (cur_word[18] == 1'b0));

    // R5
    lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we_i && csr_addr_i == 12'h7A1 && cur_word[27] && !dbg_mode_i)
        |=> (!xlat_flush_o && $stable(cur_word)));

    // R7
    aux_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_addr_i == 12'h7A3) |-> (csr_rdata_o == 32'd0));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!xlat_flush_o && !$past(rst)) |-> $stable({chk_fetch_o, chk_load_o, chk_store_o}));

    // R9
    flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
        xlat_flush_o |-> $past(csr_we_i && csr_addr_i == 12'h7A1));

endmodule

bind dbg_trig_bank dbg_trig_bank_chk #(.N_TRIG(N_TRIG), .SEL_W(SEL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .csr_addr_i   (csr_addr_i),
    .csr_wdata_i  (csr_wdata_i),
    .csr_we_i     (csr_we_i),
    .csr_rdata_o  (csr_rdata_o),
    .dbg_mode_i   (dbg_mode_i),
    .chk_fetch_o  (chk_fetch_o),
    .chk_load_o   (chk_load_o),
    .chk_store_o  (chk_store_o),
    .xlat_flush_o (xlat_flush_o),
    .sel_cur      (sel_cur),
    .cur_word     (cur_word)
);

// File: tb/dbg_trig_bank_tb_top.sv
module dbg_trig_bank_tb_top;

    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] csr_addr = 12'h000;
    logic [31:0] csr_wdata = 32'd0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_rdata;
    logic        dbg_mode = 1'b0;
    logic        chk_fetch, chk_load, chk_store, xlat_flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl [NT];
    logic [31:0] m_cmp  [NT];
    int          m_sel;

    always #5 clk = ~clk;

    dbg_trig_bank #(.N_TRIG(NT)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .csr_addr_i   (csr_addr),
        .csr_wdata_i  (csr_wdata),
        .csr_we_i     (csr_we),
        .csr_rdata_o  (csr_rdata),
        .dbg_mode_i   (dbg_mode),
        .chk_fetch_o  (chk_fetch),
        .chk_load_o   (chk_load),
        .chk_store_o  (chk_store),
        .xlat_flush_o (xlat_flush)
    );

    function automatic logic [31:0] exp_ctrl(input logic [31:0] w);
        logic [31:0] r;
        r = (w & 32'h080F_FFFF) | 32'h2000_0000;
        if (w[2]) r[18] = 1'b0;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        csr_addr = a;
        #1;
        chk(req, csr_rdata, exp);
    endtask

    task automatic check_flags();
        logic f, l, s;
        f = 1'b0; l = 1'b0; s = 1'b0;
        for (int k = 0; k < NT; k++) begin
            f |= m_ctrl[k][2]; l |= m_ctrl[k][0]; s |= m_ctrl[k][1];
        end
        chk("R8 flags", {29'd0, chk_fetch, chk_load, chk_store}, {29'd0, f, l, s});
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic lk, take_ctrl;
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_we = 1'b1;
        lk = m_ctrl[m_sel][27] && !dbg_mode;
        take_ctrl = (a == 12'h7A1) && !lk;
        if (a == 12'h7A0 && d < 32'(NT)) m_sel = int'(d);
        if (take_ctrl) m_ctrl[m_sel] = exp_ctrl(d);
        if (a == 12'h7A2 && !lk) m_cmp[m_sel] = d;
        @(negedge clk);
        csr_we = 1'b0;
        chk("R9 flush", {31'd0, xlat_flush}, {31'd0, take_ctrl});
        @(negedge clk);
        chk("R9 flush width", {31'd0, xlat_flush}, 32'd0);
        check_flags();
    endtask

    task automatic check_sel_regs(input string req);
        rd(12'h7A0, 32'(m_sel), "R2 index");
        rd(12'h7A1, m_ctrl[m_sel], req);
        rd(12'h7A2, m_cmp[m_sel], "R6 cmp");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements): actual expired expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        for (int k = 0; k < NT; k++) begin
            m_ctrl[k] = 32'h2000_0000; m_cmp[k] = 32'd0;
        end
        m_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(12'h7A0, 32'd0, "R1 index");
        chk("R1 flush", {31'd0, xlat_flush}, 32'd0);
        chk("R1 flags", {29'd0, chk_fetch, chk_load, chk_store}, 32'd0);
        for (int k = 0; k < NT; k++) begin
            wr(12'h7A0, 32'(k));
            rd(12'h7A1, 32'h2000_0000, "R1 ctrl");
            rd(12'h7A2, 32'd0, "R1 cmp");
        end

        // R2 out-of-range index keeps old value
        wr(12'h7A0, 32'd1);
        wr(12'h7A0, 32'd4);
        rd(12'h7A0, 32'd1, "R2 index 4 ignored");
        wr(12'h7A0, 32'hFFFF_FFFF);
        rd(12'h7A0, 32'd1, "R2 index max ignored");
        wr(12'h7A0, 32'h0000_0101);
        rd(12'h7A0, 32'd1, "R2 index high bits ignored");

        // R3 R4 timing without and with execute
        wr(12'h7A1, 32'h0004_0000);
        rd(12'h7A1, 32'h2004_0000, "R3 timing kept without execute");
        wr(12'h7A1, 32'hF7F4_0004);
        rd(12'h7A1, 32'h2000_0004, "R4 timing forced by execute");

        // R5 lockout
        wr(12'h7A1, 32'hFFFF_FFFF);
        rd(12'h7A1, 32'h280B_FFFF, "R3 full write");
        wr(12'h7A1, 32'h0000_0000);
        rd(12'h7A1, 32'h280B_FFFF, "R5 ctrl locked");
        wr(12'h7A2, 32'hDEAD_BEEF);
        rd(12'h7A2, 32'd0, "R5 cmp locked");
        dbg_mode = 1'b1;
        wr(12'h7A2, 32'hCAFE_0001);
        rd(12'h7A2, 32'hCAFE_0001, "R5 cmp in debug");
        wr(12'h7A1, 32'h0000_0002);
        rd(12'h7A1, 32'h2000_0002, "R5 ctrl in debug");
        dbg_mode = 1'b0;

        // R6 other slot untouched
        wr(12'h7A0, 32'd2);
        rd(12'h7A2, 32'd0, "R6 other slot");

        // R7 zero reads
        rd(12'h7A3, 32'd0, "R7 aux");
        rd(12'h123, 32'd0, "R7 unmapped");
        rd(12'h7A4, 32'd0, "R7 unmapped above");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if ($urandom_range(0, 4) == 0) dbg_mode = ~dbg_mode;
            v = $urandom;
            if (op < 3) wr(12'h7A0, (op == 0) ? v : 32'($urandom_range(0, 6)));
            else if (op < 7) begin
                if ($urandom_range(0, 2) != 0) v[27] = 1'b0;
                wr(12'h7A1, v);
            end else if (op < 9) wr(12'h7A2, v);
            else wr(12'(12'h7A0 + $urandom_range(3, 9)), v);
            check_sel_regs("R3 random ctrl");
            rd(12'h7A3, 32'd0, "R7 aux random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

endmodule